// File: doc/BRIEF.md
# Acknowledged-Transaction Sequencer

This block is the control state machine that runs a whole acknowledged packet exchange for a radio, so that the host processor never has to step through it. For a transmit transaction the host loads its data, programs a length and writes a start command. The sequencer then brings up the crystal oscillator and then the frequency synthesizer. It asks the framer to send the buffered packet, turns the radio around to receive, and listens for an acknowledgement. It finishes in a low-power rest state when that acknowledgement arrives or when a programmable wait runs out. Two separate status bits tell success apart from timeout.

For a receive transaction the same machine powers up and listens. When a valid data packet arrives it marks the data for keeping, switches to transmit, and has the framer send an acknowledgement. It then goes back to listening. Acknowledgement traffic in either direction never writes the receive buffer and never reads the transmit buffer. Each of the two power-up waits either follows a ready pin or counts a fixed number of settle cycles, chosen per wait by a parameter. The radio datapath itself is outside this block.

Top module: `ack_txn_seq`

## Requirements
- R1: After a start command is taken, the sequence is fixed: oscillator wait (osc_en high, syn_en low), then synthesizer wait (syn_en high), then data send (tx_on and tx_buf_rd high, send_data high only in its first cycle, tx_len equal to the length programmed at start), then on pkt_done the acknowledgement wait (rx_on high, tx_on low).
- R2: A wait built without a ready pin lasts exactly its settle count in cycles (OSC_CYC for the oscillator) and ignores its ready pin. A wait built with a ready pin ends on the first clock edge at which that pin is high.
- R3: In the acknowledgement wait, a pkt_valid with pkt_is_ack high ends the transaction and sets txn_ok. A valid packet with pkt_is_ack low is ignored and the wait goes on.
- R4: If the acknowledgement wait lasts limit+1 cycles with no acknowledgement, where limit is ack_tmo_cfg sampled at start, the transaction ends with txn_tmo set and txn_ok clear. An acknowledgement in that last cycle wins over the timeout.
- R5: A transaction ends in sleep (osc_en low) when end_sleep is 1 in its last cycle, otherwise in idle (osc_en high, syn_en low, busy low).
- R6: go_wr at rest raises go_bit for exactly one cycle, and go_bit clears as the sequence starts. A go_wr while busy is ignored: go_bit stays low and no transaction follows.
- R7: Starting a transmit transaction clears txn_ok and txn_tmo.
- R8: With rx_mode high at rest, the sequencer powers up into listening (rx_on). A valid packet with pkt_is_ack low raises rx_keep in the same cycle, and the next cycle shows the ACK send (tx_on, send_ack in its first cycle). After pkt_done it listens again. A valid packet with pkt_is_ack high is ignored while listening.
- R9: Dropping rx_mode while listening ends the receive session in the rest state chosen by end_sleep.
- R10: rx_keep is never high outside listening, so nothing received during an acknowledgement wait is stored. tx_buf_rd is never high while an acknowledgement is sent.
- R11: After reset the block sleeps: every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_wr | input | 1 | Write strobe of the transmit start command |
| rx_mode | input | 1 | Selects receive transaction mode |
| end_sleep | input | 1 | 1: end in sleep, 0: end in idle |
| len_cfg | input | LEN_W | Packet length register |
| ack_tmo_cfg | input | TMO_W | Acknowledgement wait limit |
| osc_rdy | input | 1 | Oscillator ready (used if OSC_RDY_PIN) |
| syn_lock | input | 1 | Synthesizer lock (used if SYN_RDY_PIN) |
| pkt_done | input | 1 | Framer finished sending a packet |
| pkt_valid | input | 1 | Framer received a valid packet |
| pkt_is_ack | input | 1 | The received packet is an acknowledgement |
| go_bit | output | 1 | Start command pending |
| busy | output | 1 | Transaction in progress |
| osc_en | output | 1 | Oscillator enable |
| syn_en | output | 1 | Synthesizer enable |
| tx_on | output | 1 | Transmitter on |
| rx_on | output | 1 | Receiver on |
| tx_buf_rd | output | 1 | Transmit buffer read enable |
| send_data | output | 1 | Start sending the data packet |
| send_ack | output | 1 | Start sending an acknowledgement |
| rx_keep | output | 1 | Store the received packet |
| tx_len | output | LEN_W | Length latched for the current packet |
| txn_ok | output | 1 | Last transmit acknowledged |
| txn_tmo | output | 1 | Last transmit timed out |

## Verification
The bench builds the block with a counted oscillator wait of five cycles and a pin-driven synthesizer wait, so both settle variants run in one build. The oscillator ready pin is held high throughout to show that the counted wait ignores it. The lock pin rises three cycles after the synthesizer is enabled. Acknowledgement limits of 2, 3 and 10 cycles make the timeout, the tie between acknowledgement and expiry, and an early acknowledgement each reachable within a handful of cycles.

// File: rtl/txn_pkg.sv
package txn_pkg;

  typedef enum logic [2:0] {
    TS_SLEEP = 3'd0,
    TS_IDLE,
    TS_OSC,
    TS_SYN,
    TS_TXD,
    TS_ACKW,
    TS_RXW,
    TS_RXACK
  } txn_state_e;

  typedef struct packed {
    logic osc;
    logic syn;
    logic tx;
    logic rx;
  } pwr_t;

  function automatic logic at_rest(txn_state_e s);
    return (s == TS_SLEEP) || (s == TS_IDLE);
  endfunction

  function automatic pwr_t pwr_of(txn_state_e s);
    pwr_t p;
    p.osc = (s != TS_SLEEP);
    p.syn = !at_rest(s) && (s != TS_OSC);
    p.tx  = (s == TS_TXD) || (s == TS_RXACK);
    p.rx  = (s == TS_ACKW) || (s == TS_RXW);
    return p;
  endfunction

endpackage

// File: rtl/txn_settle.sv
module txn_settle #(
  parameter bit USE_RDY = 1'b0,
  parameter int CYC     = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic rdy,
  output logic done
);

  generate
    if (USE_RDY) begin : g_pin
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign done = active & rdy;
    end else begin : g_cnt
      localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
      localparam logic [CW-1:0] LAST = CW'(CYC - 1);
      logic [CW-1:0] cnt;
      logic unused_rdy;

      function automatic logic hit_f(logic [CW-1:0] c);
        return c == LAST;
      endfunction

      assign unused_rdy = rdy;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (!active)       cnt <= '0;
        else if (!hit_f(cnt))   cnt <= cnt + 1'b1;
      end

      assign done = active & hit_f(cnt);
    end
  endgenerate

endmodule

// File: rtl/txn_ack_timer.sv
module txn_ack_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [TW-1:0] limit,
  output logic          expired
);

  logic [TW-1:0] cnt;

  function automatic logic reached(logic [TW-1:0] c, logic [TW-1:0] l);
    return c == l;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (!active)             cnt <= '0;
    else if (!reached(cnt, limit)) cnt <= cnt + 1'b1;
  end

  assign expired = active & reached(cnt, limit);

endmodule

// File: rtl/ack_txn_seq.sv
module ack_txn_seq
  import txn_pkg::*;
#(
  parameter int LEN_W       = 6,
  parameter int TMO_W       = 8,
  parameter int OSC_CYC     = 16,
  parameter int SYN_CYC     = 8,
  parameter bit OSC_RDY_PIN = 1'b0,
  parameter bit SYN_RDY_PIN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_wr,
  input  logic             rx_mode,
  input  logic             end_sleep,
  input  logic [LEN_W-1:0] len_cfg,
  input  logic [TMO_W-1:0] ack_tmo_cfg,
  input  logic             osc_rdy,
  input  logic             syn_lock,
  input  logic             pkt_done,
  input  logic             pkt_valid,
  input  logic             pkt_is_ack,
  output logic             go_bit,
  output logic             busy,
  output logic             osc_en,
  output logic             syn_en,
  output logic             tx_on,
  output logic             rx_on,
  output logic             tx_buf_rd,
  output logic             send_data,
  output logic             send_ack,
  output logic             rx_keep,
  output logic [LEN_W-1:0] tx_len,
  output logic             txn_ok,
  output logic             txn_tmo
);

  txn_state_e       st, st_n, end_st;
  logic             go_q, dir_rx, ok_q, tmo_q, sd_q, sa_q;
  logic [LEN_W-1:0] len_q;
  logic [TMO_W-1:0] lim_q;
  pwr_t             pwr;

  // named internal events
  logic go_take, osc_done, syn_done, tmo_exp, ack_hit, tmo_fire, rx_hit;

  txn_settle #(.USE_RDY(OSC_RDY_PIN), .CYC(OSC_CYC)) u_osc (
    .clk(clk), .rst_n(rst_n), .active(st == TS_OSC), .rdy(osc_rdy), .done(osc_done)
  );

  txn_settle #(.USE_RDY(SYN_RDY_PIN), .CYC(SYN_CYC)) u_syn (
    .clk(clk), .rst_n(rst_n), .active(st == TS_SYN), .rdy(syn_lock), .done(syn_done)
  );

  txn_ack_timer #(.TW(TMO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .active(st == TS_ACKW), .limit(lim_q), .expired(tmo_exp)
  );

  assign go_take  = at_rest(st) && go_q;
  assign ack_hit  = (st == TS_ACKW) && pkt_valid && pkt_is_ack;
  assign tmo_fire = tmo_exp && !ack_hit;
  assign rx_hit   = (st == TS_RXW) && pkt_valid && !pkt_is_ack;
  assign end_st   = end_sleep ? TS_SLEEP : TS_IDLE;

  always_comb begin
    st_n = st;
    unique case (st)
      TS_SLEEP, TS_IDLE: if (go_take || rx_mode) st_n = TS_OSC;
      TS_OSC:            if (osc_done) st_n = TS_SYN;
      TS_SYN:            if (syn_done) st_n = dir_rx ? TS_RXW : TS_TXD;
      TS_TXD:            if (pkt_done) st_n = TS_ACKW;
      TS_ACKW:           if (ack_hit || tmo_fire) st_n = end_st;
      TS_RXW: begin
        if (rx_hit)        st_n = TS_RXACK;
        else if (!rx_mode) st_n = end_st;
      end
      TS_RXACK:          if (pkt_done) st_n = TS_RXW;
      default:           st_n = TS_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= TS_SLEEP;
      go_q   <= 1'b0;
      dir_rx <= 1'b0;
      len_q  <= '0;
      lim_q  <= '0;
      ok_q   <= 1'b0;
      tmo_q  <= 1'b0;
      sd_q   <= 1'b0;
      sa_q   <= 1'b0;
    end else begin
      st <= st_n;
      if (go_take)                     go_q <= 1'b0;
      else if (go_wr && at_rest(st))   go_q <= 1'b1;
      if (at_rest(st) && st_n == TS_OSC) dir_rx <= !go_take;
      if (go_take) begin
        len_q <= len_cfg;
        lim_q <= ack_tmo_cfg;
        ok_q  <= 1'b0;
        tmo_q <= 1'b0;
      end
      if (ack_hit)  ok_q  <= 1'b1;
      if (tmo_fire) tmo_q <= 1'b1;
      sd_q <= (st_n == TS_TXD) && (st != TS_TXD);
      sa_q <= (st_n == TS_RXACK) && (st != TS_RXACK);
    end
  end

  assign pwr       = pwr_of(st);
  assign osc_en    = pwr.osc;
  assign syn_en    = pwr.syn;
  assign tx_on     = pwr.tx;
  assign rx_on     = pwr.rx;
  assign busy      = !at_rest(st);
  assign tx_buf_rd = (st == TS_TXD);
  assign send_data = sd_q;
  assign send_ack  = sa_q;
  assign rx_keep   = rx_hit;
  assign go_bit    = go_q;
  assign tx_len    = len_q;
  assign txn_ok    = ok_q;
  assign txn_tmo   = tmo_q;

endmodule

// File: rtl/txn_seq_chk.sv
module txn_seq_chk
  import txn_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input txn_state_e st,
  input logic       go_wr,
  input logic       go_bit,
  input logic       go_take,
  input logic       ack_hit,
  input logic       tmo_fire,
  input logic       end_sleep,
  input logic       rx_keep,
  input logic       send_ack,
  input logic       txn_ok,
  input logic       txn_tmo,
  input logic       busy
);

  assert_go_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    go_take |=> (st == TS_OSC));

  assert_tx_after_syn_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TS_TXD && $past(st) != TS_TXD) |-> ($past(st) == TS_SYN));

  assert_ack_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |=> (txn_ok && !busy));

  assert_timeout_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fire |=> (txn_tmo && !txn_ok && !busy));

  assert_end_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit || tmo_fire) |=> ((st == TS_SLEEP) == $past(end_sleep)));

  assert_go_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go_wr && !go_bit) |=> !go_bit);

  assert_rx_answer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_keep |=> (send_ack && st == TS_RXACK));

endmodule

bind ack_txn_seq txn_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .go_wr(go_wr), .go_bit(go_bit),
  .go_take(go_take), .ack_hit(ack_hit), .tmo_fire(tmo_fire),
  .end_sleep(end_sleep), .rx_keep(rx_keep), .send_ack(send_ack),
  .txn_ok(txn_ok), .txn_tmo(txn_tmo), .busy(busy)
);

// File: tb/tb_ack_txn_seq.sv
module tb_ack_txn_seq;

  localparam int LEN_W   = 6;
  localparam int TMO_W   = 8;
  localparam int OSC_CYC = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic go_wr = 0, rx_mode = 0, end_sleep = 0, osc_rdy = 1, syn_lock = 0;
  logic pkt_done = 0, pkt_valid = 0, pkt_is_ack = 0;
  logic [LEN_W-1:0] len_cfg = '0;
  logic [TMO_W-1:0] ack_tmo_cfg = '0;
  logic go_bit, busy, osc_en, syn_en, tx_on, rx_on, tx_buf_rd;
  logic send_data, send_ack, rx_keep, txn_ok, txn_tmo;
  logic [LEN_W-1:0] tx_len;

  int n_chk = 0, n_bad = 0, wd = 0, lock_cnt = 0, n;

  always #10 clk = ~clk;

  ack_txn_seq #(.LEN_W(LEN_W), .TMO_W(TMO_W), .OSC_CYC(OSC_CYC), .SYN_CYC(4),
                .OSC_RDY_PIN(1'b0), .SYN_RDY_PIN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .go_wr(go_wr), .rx_mode(rx_mode), .end_sleep(end_sleep),
    .len_cfg(len_cfg), .ack_tmo_cfg(ack_tmo_cfg), .osc_rdy(osc_rdy), .syn_lock(syn_lock),
    .pkt_done(pkt_done), .pkt_valid(pkt_valid), .pkt_is_ack(pkt_is_ack),
    .go_bit(go_bit), .busy(busy), .osc_en(osc_en), .syn_en(syn_en), .tx_on(tx_on),
    .rx_on(rx_on), .tx_buf_rd(tx_buf_rd), .send_data(send_data), .send_ack(send_ack),
    .rx_keep(rx_keep), .tx_len(tx_len), .txn_ok(txn_ok), .txn_tmo(txn_tmo)
  );

  // synthesizer model: lock three cycles after enable
  always @(negedge clk) begin
    lock_cnt = syn_en ? lock_cnt + 1 : 0;
    syn_lock = (lock_cnt >= 3);
  end

  // behavioural reference: phase 0 sleep,1 idle,2 osc,3 syn,4 send,5 ack wait,6 listen,7 answer
  int   ph = 0, nph, cnt = 0, endp, m_len = 0, m_lim = 0;
  logic m_go = 0, old_go, m_dir = 0, m_ok = 0, m_tmo = 0, m_sd = 0, m_sa = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; cnt = 0; m_go = 0; m_ok = 0; m_tmo = 0; m_len = 0; m_lim = 0;
      m_dir = 0; m_sd = 0; m_sa = 0;
    end else begin
      nph = ph; old_go = m_go;
      endp = end_sleep ? 0 : 1;
      if (ph <= 1) begin
        if (m_go) begin
          nph = 2; m_dir = 0; m_len = len_cfg; m_lim = ack_tmo_cfg; m_ok = 0; m_tmo = 0;
        end else if (rx_mode) begin
          nph = 2; m_dir = 1;
        end
      end else if (ph == 2) begin
        if (cnt == OSC_CYC - 1) nph = 3;
      end else if (ph == 3) begin
        if (syn_lock) nph = m_dir ? 6 : 4;
      end else if (ph == 4) begin
        if (pkt_done) nph = 5;
      end else if (ph == 5) begin
        if (pkt_valid && pkt_is_ack) begin nph = endp; m_ok = 1; end
        else if (cnt == m_lim) begin nph = endp; m_tmo = 1; end
      end else if (ph == 6) begin
        if (pkt_valid && !pkt_is_ack) nph = 7;
        else if (!rx_mode) nph = endp;
      end else begin
        if (pkt_done) nph = 6;
      end
      if (ph <= 1 && old_go) m_go = 0;
      else if (ph <= 1 && go_wr) m_go = 1;
      m_sd = (nph == 4 && ph != 4);
      m_sa = (nph == 7 && ph != 7);
      cnt  = (nph == ph) ? cnt + 1 : 0;
      ph   = nph;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk("R1 osc_en",    osc_en,    ph != 0);
    chk("R1 syn_en",    syn_en,    ph >= 3);
    chk("R1 tx_on",     tx_on,     ph == 4 || ph == 7);
    chk("R1 rx_on",     rx_on,     ph == 5 || ph == 6);
    chk("R1 busy",      busy,      ph >= 2);
    chk("R10 tx_buf_rd", tx_buf_rd, ph == 4);
    chk("R1 send_data", send_data, m_sd);
    chk("R8 send_ack",  send_ack,  m_sa);
    chk("R10 rx_keep",  rx_keep,   ph == 6 && pkt_valid && !pkt_is_ack);
    chk("R6 go_bit",    go_bit,    m_go);
    chk("R3 txn_ok",    txn_ok,    m_ok);
    chk("R4 txn_tmo",   txn_tmo,   m_tmo);
    chk("R1 tx_len",    tx_len,    m_len);
  endtask

  task automatic tick();
    @(negedge clk); #1;
    compare();
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog act=%0d exp<20000", wd);
      finish_up();
    end
  end

  task automatic start_tx(input int len, input int lim, input logic sleep_end);
    len_cfg = LEN_W'(len); ack_tmo_cfg = TMO_W'(lim); end_sleep = sleep_end;
    go_wr = 1; tick(); go_wr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    chk("R11 reset osc_en", osc_en, 0);
    chk("R11 reset busy", busy, 0);
    chk("R11 reset status", {txn_ok, txn_tmo, go_bit}, 0);

    // acknowledged transmit, end in idle
    start_tx(37, 10, 0);
    chk("R6 go_bit raised", go_bit, 1);
    tick();
    chk("R6 go_bit self-clear", go_bit, 0);
    n = 1;
    while (!syn_en) begin tick(); if (!syn_en) n++; end
    chk("R2 counted oscillator wait", n, OSC_CYC);
    while (!tx_on) tick();
    chk("R1 send_data first cycle", send_data, 1);
    chk("R1 latched length", tx_len, 37);
    go_wr = 1; tick(); go_wr = 0;
    chk("R6 busy write ignored", go_bit, 0);
    pkt_done = 1; tick(); pkt_done = 0;
    chk("R1 turnaround rx_on", rx_on, 1);
    pkt_valid = 1; pkt_is_ack = 0; #1;
    chk("R10 no keep in ack wait", rx_keep, 0);
    tick(); pkt_valid = 0;
    chk("R3 foreign packet ignored", rx_on, 1);
    tick();
    pkt_valid = 1; pkt_is_ack = 1; tick(); pkt_valid = 0; pkt_is_ack = 0;
    chk("R3 ack ends", {busy, txn_ok, txn_tmo}, 3'b010);
    chk("R5 idle end", {osc_en, syn_en}, 2'b10);
    tick(); tick();
    chk("R6 no transaction from ignored write", busy, 0);

    // timeout, end in sleep
    start_tx(5, 3, 1);
    tick();
    chk("R7 ok cleared at start", txn_ok, 0);
    while (!tx_on) tick();
    pkt_done = 1; tick(); pkt_done = 0;
    n = 1;
    while (busy) begin tick(); if (busy) n++; end
    chk("R4 wait length limit+1", n, 4);
    chk("R4 timeout status", {txn_tmo, txn_ok}, 2'b10);
    chk("R5 sleep end", osc_en, 0);

    // ack in the expiry cycle wins
    start_tx(12, 2, 0);
    tick();
    chk("R7 timeout cleared at start", txn_tmo, 0);
    while (!tx_on) tick();
    pkt_done = 1; tick(); pkt_done = 0;
    tick(); tick();
    pkt_valid = 1; pkt_is_ack = 1; tick(); pkt_valid = 0; pkt_is_ack = 0;
    chk("R4 ack wins tie", {txn_ok, txn_tmo, busy}, 3'b100);

    // receive transaction
    end_sleep = 1; rx_mode = 1;
    tick();
    while (!rx_on) tick();
    chk("R8 listening", {rx_on, tx_on}, 2'b10);
    go_wr = 1; tick(); go_wr = 0;
    chk("R6 go ignored while listening", go_bit, 0);
    pkt_valid = 1; pkt_is_ack = 1; #1;
    chk("R8 ack packet not kept", rx_keep, 0);
    tick(); pkt_valid = 0; pkt_is_ack = 0;
    chk("R8 ack packet ignored", {rx_on, send_ack}, 2'b10);
    pkt_valid = 1; #1;
    chk("R8 data packet kept", rx_keep, 1);
    tick(); pkt_valid = 0;
    chk("R8 answer starts", {send_ack, tx_on}, 2'b11);
    chk("R10 no buffer read on ack", tx_buf_rd, 0);
    tick();
    chk("R8 send_ack one cycle", send_ack, 0);
    pkt_done = 1; tick(); pkt_done = 0;
    chk("R8 back to listening", rx_on, 1);
    rx_mode = 0; tick();
    chk("R9 session ends asleep", {busy, osc_en}, 2'b00);
    tick(); tick();
    finish_up();
  end

endmodule